// File: doc/BRIEF.md
# Polyphase FIR rational resampler

This block changes the sample rate of a stream by the rational factor L/M. In effect it places L-1 zeros after every input sample, runs the result through a low-pass FIR filter, and keeps one filtered value out of every M. It is built in polyphase form. Products against the inserted zeros are never computed, and outputs that decimation would discard are never formed. Each output is a short dot product between the most recent inputs and one sub-filter. A phase register selects that sub-filter.

Several channels enter side by side on one wide data word. They share the control logic and the coefficients, and every channel moves one sample per cycle. L, M, the tap count, the coefficient set and all widths are fixed at elaboration. The full-precision sum is shifted right, rounded to nearest and clipped to the output width.

Upstream logic may follow the `ready` output. It may instead present valid samples no more often than once every ceil(L/M) cycles, which never loses a sample.

Top module: `polyfir_resampler`

## Requirements
- R1: After n > 0 accepted samples and enough idle cycles, exactly floor((n*L-1)/M)+1 outputs have been produced since reset.
- R2: Output number k (counting from 0 after reset) equals the rounded and clipped value of the sum over taps t of h[t]*u[k*M-t]. Here u[q] is x[q/L] when q >= 0 and q is a multiple of L, and 0 otherwise. Coefficient t is held in bits [t*CW +: CW] of the coefficient parameter, so h[0] multiplies the newest sample.
- R3: Channel c uses bits [c*DW +: DW] of the input and bits [c*OW +: OW] of the output. Channels never affect one another.
- R4: With `in_valid` low, `in_data` has no effect. `out_valid` is high only in cycles that carry a newly computed sample.
- R5: A sample presented in a cycle is accepted only if `ready` was high in the previous cycle. Otherwise it is ignored.
- R6: In the first cycle after reset is released, `ready` is high with `in_valid` low, and a sample presented in that cycle is accepted. `out_valid` and `out_data` are zero.
- R7: A source that presents a valid sample every ceil(L/M) cycles and ignores `ready` never loses a sample.
- R8: Reset clears every delay-line entry to zero. Outputs after a reset depend only on samples accepted after it.
- R9: The sum is divided by 2^SHIFT and rounded to nearest, with halves going toward plus infinity. It is then clipped to the signed OW-bit range.
- R10: An output whose newest needed sample was accepted in cycle t appears with `out_valid` in cycle t+2 at the earliest. The first output after reset appears exactly then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | CH*DW | Signed input samples, channel 0 in the low bits |
| ready | output | 1 | High: a sample presented in the next cycle is accepted |
| out_valid | output | 1 | High when out_data holds a new result |
| out_data | output | CH*OW | Signed resampled outputs, channel 0 in the low bits |

## Verification
A phase register that steps wrong picks the wrong sub-filter. The next output value is then wrong, and the total output count drifts from floor((n*L-1)/M)+1 within one input period. A miscounted input-need register shows up as a dropped or duplicated input. This appears within a few cycles, either as an output that disagrees with the zero-stuffed convolution or as a cadence-driven sample that lands while `ready` was low. A delay line that is not cleared by reset shows in the first output after a reset in mid-stream.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int COEF_BUS = 4096;

  function automatic longint rnd_sat(input longint v, input int sh, input int ow);
    longint r;
    longint hi;
    longint lo;
    if (sh > 0) r = (v + (longint'(1) <<< (sh - 1))) >>> sh;
    else r = v;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -hi - 1;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  function automatic logic [COEF_BUS-1:0] tri_pack(input int taps, input int cw);
    logic [COEF_BUS-1:0] r;
    int v;
    r = '0;
    for (int k = 0; k < taps; k++) begin
      v = (k + 1 < taps - k) ? k + 1 : taps - k;
      v = v * ((1 << (cw - 2)) / ((taps + 1) / 2));
      for (int b = 0; b < cw; b++) r[k*cw+b] = v[b];
    end
    return r;
  endfunction
endpackage

// File: rtl/rr_phase_ctrl.sv
module rr_phase_ctrl #(
  parameter int L   = 5,
  parameter int M   = 2,
  parameter int PW  = 3,
  parameter int NDW = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           accept,
  output logic           emit,
  output logic           ready,
  output logic [PW-1:0]  ph,
  output logic [NDW-1:0] need
);
  logic           acc_en;
  logic [PW-1:0]  ph_n;
  logic [NDW-1:0] need_n;
  int pe;
  int ne;
  int nn;

  always_comb begin
    emit   = (need == '0);
    accept = in_valid && acc_en;
    if (emit) begin
      pe = (int'(ph) + M) % L;
      ne = (int'(ph) + M) / L;
    end else begin
      pe = int'(ph);
      ne = int'(need);
    end
    nn     = accept ? ne - 1 : ne;
    ph_n   = PW'(pe);
    need_n = NDW'(nn);
    ready  = (nn > 0) || (pe + M >= L);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= '0;
      need   <= NDW'(1);
      acc_en <= 1'b1;
    end else begin
      ph     <= ph_n;
      need   <= need_n;
      acc_en <= ready;
    end
  end
endmodule

// File: rtl/rr_chan_mac.sv
module rr_chan_mac #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 16,
  parameter int TAPS  = 71,
  parameter int L     = 5,
  parameter int NS    = 15,
  parameter int PW    = 3,
  parameter int SHIFT = 15,
  parameter int AW    = 36,
  parameter logic [rr_pkg::COEF_BUS-1:0] COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 emit,
  input  logic [PW-1:0]        ph,
  input  logic signed [DW-1:0] din,
  output logic signed [OW-1:0] dout
);
  logic signed [DW-1:0] dl [NS];
  logic signed [AW-1:0] acc;
  logic signed [CW-1:0] c;
  int idx;

  // newest sample sits in dl[0]
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NS; j++) dl[j] <= '0;
    end else if (accept) begin
      for (int j = NS - 1; j > 0; j--) dl[j] <= dl[j-1];
      dl[0] <= din;
    end
  end

  // sub-filter ph uses taps ph, ph+L, ph+2L, ...
  always_comb begin
    acc = '0;
    c   = '0;
    idx = 0;
    for (int j = 0; j < NS; j++) begin
      idx = int'(ph) + j * L;
      if (idx < TAPS) begin
        c   = COEFS[idx*CW +: CW];
        acc = acc + AW'(dl[j]) * AW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else if (emit) dout <= OW'(rr_pkg::rnd_sat(longint'(acc), SHIFT, OW));
  end
endmodule

// File: rtl/polyfir_resampler.sv
module polyfir_resampler #(
  parameter int CH    = 2,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 16,
  parameter int TAPS  = 71,
  parameter int L     = 5,
  parameter int M     = 2,
  parameter int SHIFT = 15,
  parameter logic [rr_pkg::COEF_BUS-1:0] COEFS = rr_pkg::tri_pack(TAPS, CW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [CH*DW-1:0] in_data,
  output logic            ready,
  output logic            out_valid,
  output logic [CH*OW-1:0] out_data
);
  localparam int NS      = (TAPS + L - 1) / L;
  localparam int PW      = (L > 1) ? $clog2(L) : 1;
  localparam int MAXNEED = (L - 1 + M) / L;
  localparam int NDW     = $clog2(MAXNEED + 1);
  localparam int AW      = DW + CW + $clog2(NS + 1);

  logic           accept;
  logic           emit;
  logic [PW-1:0]  ph;
  logic [NDW-1:0] need;

  rr_phase_ctrl #(.L(L), .M(M), .PW(PW), .NDW(NDW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .accept(accept), .emit(emit), .ready(ready), .ph(ph), .need(need)
  );

  for (genvar g = 0; g < CH; g++) begin : g_chan
    rr_chan_mac #(
      .DW(DW), .CW(CW), .OW(OW), .TAPS(TAPS), .L(L), .NS(NS),
      .PW(PW), .SHIFT(SHIFT), .AW(AW), .COEFS(COEFS)
    ) u_mac (
      .clk(clk), .rst_n(rst_n), .accept(accept), .emit(emit), .ph(ph),
      .din(in_data[g*DW +: DW]), .dout(out_data[g*OW +: OW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else out_valid <= emit;
  end
endmodule

// File: rtl/polyfir_resampler_chk.sv
module polyfir_resampler_chk #(
  parameter int L   = 5,
  parameter int M   = 2,
  parameter int PW  = 3,
  parameter int NDW = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           accept,
  input logic           emit,
  input logic           out_valid,
  input logic [PW-1:0]  ph,
  input logic [NDW-1:0] need
);
  a_r5_blocked_sample_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !accept);

  a_r4_out_valid_from_emit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(emit));

  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ph) < L);

  a_r2_emit_follows_last_need: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && need == NDW'(1)) |=> emit);

  a_r7_accept_when_room: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (emit ? (int'(ph) + M >= L) : (need != '0)));
endmodule

bind polyfir_resampler polyfir_resampler_chk #(.L(L), .M(M), .PW(PW), .NDW(NDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .accept(accept), .emit(emit),
  .out_valid(out_valid), .ph(ph), .need(need)
);

// File: tb/polyfir_resampler_lane.sv
module polyfir_resampler_lane #(
  parameter int L    = 5,
  parameter int M    = 2,
  parameter int TAPS = 11
) (
  input  logic clk,
  output logic done,
  output int   checks,
  output int   errs
);
  localparam int CH = 2, DW = 8, CW = 6, OW = 8, SH = 4;
  localparam int CAD = (L + M - 1) / M;

  function automatic int hval(input int k);
    return ((k * 7 + 3) % 19) - 4;
  endfunction

  function automatic logic [rr_pkg::COEF_BUS-1:0] pack_h();
    logic [rr_pkg::COEF_BUS-1:0] r;
    int v;
    r = '0;
    for (int k = 0; k < TAPS; k++) begin
      v = hval(k);
      for (int b = 0; b < CW; b++) r[k*CW+b] = v[b];
    end
    return r;
  endfunction

  localparam logic [rr_pkg::COEF_BUS-1:0] HPACK = pack_h();

  logic            rst_n;
  logic            in_valid;
  logic [CH*DW-1:0] in_data;
  logic            ready;
  logic            out_valid;
  logic [CH*OW-1:0] out_data;

  polyfir_resampler #(
    .CH(CH), .DW(DW), .CW(CW), .OW(OW), .TAPS(TAPS), .L(L), .M(M),
    .SHIFT(SH), .COEFS(HPACK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .ready(ready), .out_valid(out_valid), .out_data(out_data)
  );

  int    hist [CH][512];
  int    cnt, nout, cyc, acc0_cyc;
  logic  rdy_prev, first, cad_mode, chk_cnt;
  string tag;

  function automatic int expect_out(input int ch, input int n);
    longint y;
    real r;
    int q;
    y = 0;
    for (int k = 0; k < TAPS; k++) begin
      q = n * M - k;
      if (q >= 0 && q % L == 0 && q / L < cnt && q / L < 512)
        y += longint'(hval(k)) * longint'(hist[ch][q/L]);
    end
    r = $floor(real'(y) / (2.0 ** SH) + 0.5);
    if (r > 127.0) r = 127.0;
    if (r < -128.0) r = -128.0;
    return int'(r);
  endfunction

  task automatic check(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s L=%0d M=%0d: got %0d expected %0d", what, L, M, got, exp);
    end
  endtask

  initial begin
    checks = 0; errs = 0; cnt = 0; nout = 0; cyc = 0; acc0_cyc = 0;
    rdy_prev = 1'b1; first = 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      cnt = 0; nout = 0; rdy_prev = 1'b1; first = 1'b1;
    end else begin
      if (first) begin
        check(ready == 1'b1, "R6 ready after reset", int'(ready), 1);
        check(out_valid == 1'b0 && out_data == '0, "R6 outputs idle after reset",
              int'(out_data), 0);
        first = 1'b0;
      end
      if (cad_mode && in_valid)
        check(rdy_prev == 1'b1, "R7 cadence sample dropped", int'(rdy_prev), 1);
      if (in_valid && rdy_prev) begin
        for (int c = 0; c < CH; c++) begin
          logic signed [DW-1:0] s;
          s = in_data[c*DW +: DW];
          if (cnt < 512) hist[c][cnt] = int'(s);
        end
        if (cnt == 0) acc0_cyc = cyc;
        cnt++;
      end
      if (out_valid) begin
        if (nout == 0) check(cyc - acc0_cyc == 2, "R10 first output latency", cyc - acc0_cyc, 2);
        for (int c = 0; c < CH; c++) begin
          logic signed [OW-1:0] g;
          int e;
          g = out_data[c*OW +: OW];
          e = expect_out(c, nout);
          check(int'(g) == e, tag, int'(g), e);
        end
        nout++;
      end
      if (chk_cnt) begin
        int e;
        e = (cnt > 0) ? (cnt * L - 1) / M + 1 : 0;
        check(nout == e, "R1 output count", nout, e);
      end
      rdy_prev = ready;
    end
  end

  task automatic step(input logic v, input int d0, input int d1);
    @(posedge clk);
    #1;
    in_valid = v;
    in_data  = {DW'(d1), DW'(d0)};
    chk_cnt  = 1'b0;
  endtask

  task automatic drain_and_count();
    repeat (30) step(1'b0, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk_cnt  = 1'b1;
    step(1'b0, 0, 0);
  endtask

  initial begin
    done = 1'b0; rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    cad_mode = 1'b0; chk_cnt = 1'b0; tag = "R2 R3 R4 sample value";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1'b0, 0, 0);
    // ready-driven random stream with gaps carrying garbage data
    repeat (80) step(rdy_prev && ($urandom_range(0, 3) != 0),
                     int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    tag = "R9 saturation and rounding";
    for (int i = 0; i < 24; i++)
      step(rdy_prev, (i < 12) ? 127 : -128, (i < 12) ? -128 : 127);
    drain_and_count();
    // reset in mid-stream, then fixed cadence that ignores ready
    @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R8 R2 value after reset";
    cad_mode = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step(1'b1, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
      for (int w = 1; w < CAD; w++) step(1'b0, 255, 1);
    end
    cad_mode = 1'b0;
    drain_and_count();
    // overrun: valid every cycle regardless of ready
    tag = "R5 R3 value under overrun";
    repeat (40) step(1'b1, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    drain_and_count();
    done = 1'b1;
  end
endmodule

// File: tb/polyfir_resampler_tb.sv
`timescale 1ns/1ps
module polyfir_resampler_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic done_up, done_dn;
  int   chk_up, chk_dn, err_up, err_dn;

  polyfir_resampler_lane #(.L(5), .M(2), .TAPS(11)) u_up (
    .clk(clk), .done(done_up), .checks(chk_up), .errs(err_up)
  );

  polyfir_resampler_lane #(.L(2), .M(3), .TAPS(7)) u_dn (
    .clk(clk), .done(done_dn), .checks(chk_dn), .errs(err_dn)
  );

  initial begin
    int n;
    int total_chk;
    int total_err;
    n = 0;
    while (!(done_up === 1'b1 && done_dn === 1'b1) && n < 200000) begin
      @(posedge clk);
      n++;
    end
    total_chk = chk_up + chk_dn;
    total_err = err_up + err_dn;
    if (n >= 200000) begin
      total_chk++;
      total_err++;
      $display("FAIL watchdog: got %0d cycles expected completion", n);
    end
    $display("Simulation finished: %0d checks, %0d errors", total_chk, total_err);
    $finish;
  end
endmodule